// File: doc/BRIEF.md
# Fixed-Priority Bus Ownership Arbiter

This block decides which of four masters owns a shared system bus: an off-chip master, a memory refresh engine, a DMA engine and the CPU. The three non-CPU masters each drive a request line. The CPU needs no request line because it owns the bus by default whenever nobody else wants it. Ownership is reported on a registered, one-hot acknowledge vector. A change of owner takes one clock edge: the old acknowledge falls and the new one rises together.

A higher-priority request does not take the bus at once. Each owner has its own legal release points. A non-CPU owner gives up the bus when it drops its request. It can also be preempted when it flags the end of a bus cycle. The CPU hands over at the end of a bus cycle, unless it is between the two halves of a word that it is moving as two byte transfers. It also hands over at once when it is only computing internally or is asleep.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While reset is high, and on the first edge after it, the acknowledge vector is 4'b1000: only the CPU bit (bit 3) is set.
- R2: Exactly one acknowledge bit is set in every cycle after reset.
- R3: A non-CPU acknowledge bit (bit 0 off-chip, bit 1 refresh, bit 2 DMA) is set only if the matching request bit was high in the previous cycle.
- R4: When the bus changes hands, it goes to the lowest-numbered active request (0 off-chip > 1 refresh > 2 DMA), or to the CPU if no request is active.
- R5: A non-CPU owner keeps the bus while its request stays high and its own cycle-end bit is low, whatever the other masters request.
- R6: When a non-CPU owner drops its request, the bus is re-arbitrated on the next edge.
- R7: A non-CPU owner whose own cycle-end bit is high is preempted on that edge if a higher-priority request is active.
- R8: When the CPU owns the bus, some request is active, cycle-end bit 3 is high and the split-word lock is low, the bus passes to the winner on that edge.
- R9: While the split-word lock is high, the CPU keeps the bus whatever the other inputs are.
- R10: When the CPU owns the bus and its internal-operation input is high, an active request takes the bus on the next edge even with cycle-end bit 3 low.
- R11: When the CPU owns the bus and its sleep input is high, an active request takes the bus on the next edge even with cycle-end bit 3 low.
- R12: With no request active, the CPU keeps the bus whatever the status inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 3 | Requests: bit 0 off-chip, bit 1 refresh, bit 2 DMA |
| cyc_end | input | 4 | Per-master end-of-bus-cycle flag, same bit order, bit 3 CPU |
| cpu_split_lock | input | 1 | CPU is between the two byte halves of a word transfer |
| cpu_internal | input | 1 | CPU is doing internal work only (multiply, divide) |
| cpu_sleep | input | 1 | CPU is in sleep mode |
| ack | output | 4 | Registered one-hot ownership, bit 3 CPU |

## Verification
The bench targets the hold-versus-preempt boundary. A design that ignores the owner's cycle-end flag would snatch the bus from a DMA or off-chip owner in the middle of a cycle. A design that waits for it when the owner drops its request would leave the bus stranded. The split-word lock is exercised together with internal and sleep indications, so a design that lets those override the lock shows a handover between the byte halves. Simultaneous requests, and a release with lower-priority requests still waiting, expose wrong ordering. A long random phase compares every cycle against a behavioural model and catches a double or missing acknowledge.

// File: rtl/arb_pkg.sv
package arb_pkg;
  parameter int unsigned DEF_MASTERS = 4;

  typedef struct packed {
    logic split_lock;
    logic internal_op;
    logic asleep;
  } cpu_state_t;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick
);
  // lowest index has highest priority
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign pick[i] = cand[i];
    end else begin : g_rest
      assign pick[i] = cand[i] & ~(|cand[i-1:0]);
    end
  end
endmodule

// File: rtl/arb_release_gate.sv
module arb_release_gate
  import arb_pkg::*;
#(
  parameter int unsigned N    = 4,
  localparam int unsigned NREQ = N - 1,
  localparam int unsigned CPU  = N - 1
) (
  input  logic [N-1:0]    owner,
  input  logic [NREQ-1:0] req,
  input  logic [N-1:0]    cyc_end,
  input  cpu_state_t      cpu_st,
  output logic            handover
);
  logic [N-1:0] rel;

  for (genvar i = 0; i < NREQ; i++) begin : g_master
    logic higher;
    if (i == 0) begin : g_none
      assign higher = 1'b0;
    end else begin : g_some
      assign higher = |req[i-1:0];
    end
    // leave on request drop, or yield to a better master at cycle end
    assign rel[i] = owner[i] & (~req[i] | (higher & cyc_end[i]));
  end

  logic cpu_window;
  assign cpu_window = ~cpu_st.split_lock &
                      (cpu_st.asleep | cpu_st.internal_op | cyc_end[CPU]);
  assign rel[CPU] = owner[CPU] & (|req) & cpu_window;

  assign handover = |rel;
endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_MASTERS = DEF_MASTERS,
  localparam int unsigned NREQ = N_MASTERS - 1,
  localparam int unsigned CPU  = N_MASTERS - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREQ-1:0]      bus_req,
  input  logic [N_MASTERS-1:0] cyc_end,
  input  logic                 cpu_split_lock,
  input  logic                 cpu_internal,
  input  logic                 cpu_sleep,
  output logic [N_MASTERS-1:0] ack
);
  localparam logic [N_MASTERS-1:0] CPU_OH = {1'b1, {NREQ{1'b0}}};

  logic [N_MASTERS-1:0] owner_q;
  logic [N_MASTERS-1:0] cand;
  logic [N_MASTERS-1:0] winner;
  logic                 handover;
  cpu_state_t           cpu_st;

  assign cand   = {1'b1, bus_req};
  assign cpu_st = '{split_lock: cpu_split_lock,
                    internal_op: cpu_internal,
                    asleep: cpu_sleep};

  arb_prio_pick #(.N(N_MASTERS)) u_pick (
    .cand (cand),
    .pick (winner)
  );

  arb_release_gate #(.N(N_MASTERS)) u_gate (
    .owner    (owner_q),
    .req      (bus_req),
    .cyc_end  (cyc_end),
    .cpu_st   (cpu_st),
    .handover (handover)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= CPU_OH;
    end else if (handover) begin
      owner_q <= winner;
    end
  end

  assign ack = owner_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned N = 4,
  localparam int unsigned NREQ = N - 1,
  localparam int unsigned CPU  = N - 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] bus_req,
  input logic [N-1:0]    cyc_end,
  input logic            cpu_split_lock,
  input logic            cpu_internal,
  input logic            cpu_sleep,
  input logic [N-1:0]    ack
);
  AST_RESET_CPU: assert property (@(posedge clk) rst |=> (ack == {1'b1, {NREQ{1'b0}}})); // R1
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst) $countones(ack) == 1); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ack[CPU] && cpu_split_lock) |=> ack[CPU]); // R9
  AST_CPU_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (ack[CPU] && (|bus_req) && !cpu_split_lock && cyc_end[CPU]) |=> !ack[CPU]); // R8
  AST_INTERNAL_YIELD: assert property (@(posedge clk) disable iff (rst)
    (ack[CPU] && (|bus_req) && !cpu_split_lock && cpu_internal) |=> !ack[CPU]); // R10
  AST_SLEEP_YIELD: assert property (@(posedge clk) disable iff (rst)
    (ack[CPU] && (|bus_req) && !cpu_split_lock && cpu_sleep) |=> !ack[CPU]); // R11
  AST_CPU_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ack[CPU] && !(|bus_req)) |=> ack[CPU]); // R12

  for (genvar i = 0; i < NREQ; i++) begin : g_m
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      $rose(ack[i]) |-> $past(bus_req[i])); // R3
    AST_OWNER_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && bus_req[i] && !cyc_end[i]) |=> ack[i]); // R5
    AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && !bus_req[i]) |=> !ack[i]); // R6
    if (i > 0) begin : g_pre
      AST_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (ack[i] && (|bus_req[i-1:0]) && cyc_end[i]) |=> !ack[i]); // R7
    end
  end
endmodule

bind bus_owner_arbiter arb_checker #(.N(N_MASTERS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_req        (bus_req),
  .cyc_end        (cyc_end),
  .cpu_split_lock (cpu_split_lock),
  .cpu_internal   (cpu_internal),
  .cpu_sleep      (cpu_sleep),
  .ack            (ack)
);

// File: tb/tb_bus_owner_arbiter.sv
`timescale 1ns/1ps
module tb_bus_owner_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_req = '0;
  logic [3:0] cyc_end = '0;
  logic       cpu_split_lock = 1'b0;
  logic       cpu_internal = 1'b0;
  logic       cpu_sleep = 1'b0;
  logic [3:0] ack;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int model_owner = 3;
  bit model_on = 1'b0;
  logic [2:0] prev_req = '0;

  always #4 clk = ~clk;

  bus_owner_arbiter dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .cyc_end(cyc_end),
    .cpu_split_lock(cpu_split_lock), .cpu_internal(cpu_internal),
    .cpu_sleep(cpu_sleep), .ack(ack)
  );

  // behavioural reference: integer owner index, 3 = CPU
  always @(posedge clk) begin
    int best;
    best = 3;
    for (int k = 2; k >= 0; k--) if (bus_req[k]) best = k;
    if (rst) begin
      model_owner = 3;
    end else if (model_owner == 3) begin
      if (best != 3 && !cpu_split_lock && (cpu_sleep || cpu_internal || cyc_end[3]))
        model_owner = best;
    end else if (!bus_req[model_owner]) begin
      model_owner = best;
    end else if (best < model_owner && cyc_end[model_owner]) begin
      model_owner = best;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      finish_run();
    end
  end

  // every-cycle comparison against the model, plus one-hot and request history
  always @(negedge clk) begin
    if (model_on) begin
      logic [3:0] exp;
      exp = 4'b0001 << model_owner;
      checks++;
      if (ack !== exp) begin
        errors++;
        $display("FAIL R4 model: actual %b expected %b", ack, exp);
      end
      checks++;
      if ($countones(ack) != 1) begin
        errors++;
        $display("FAIL R2 one-hot: actual %b expected one bit", ack);
      end
      for (int k = 0; k < 3; k++) begin
        if (ack[k] && !prev_req[k]) begin
          errors++;
          $display("FAIL R3 grant without request: actual ack %b expected prior req bit %0d", ack, k);
        end
      end
      checks++;
    end
    prev_req = bus_req;
  end

  task automatic expect_ack(input string tag, input logic [3:0] exp);
    checks++;
    if (ack !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, ack, exp);
    end
  endtask

  task automatic step(input logic [2:0] r, input logic [3:0] ce,
                      input logic lk, input logic it, input logic sl);
    bus_req = r; cyc_end = ce; cpu_split_lock = lk; cpu_internal = it; cpu_sleep = sl;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_ack("R1 during reset", 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    model_on = 1'b1;
    expect_ack("R1 after reset", 4'b1000);

    step(3'b000, 4'b1111, 1'b0, 1'b1, 1'b1); expect_ack("R12 idle cpu", 4'b1000);
    step(3'b100, 4'b1000, 1'b1, 1'b1, 1'b0); expect_ack("R9 lock vs internal", 4'b1000);
    step(3'b100, 4'b1000, 1'b1, 1'b0, 1'b1); expect_ack("R9 lock vs sleep", 4'b1000);
    step(3'b100, 4'b1000, 1'b0, 1'b0, 1'b0); expect_ack("R8 cpu boundary", 4'b0100);
    step(3'b101, 4'b0000, 1'b0, 1'b0, 1'b0); expect_ack("R5 dma keeps", 4'b0100);
    step(3'b101, 4'b1011, 1'b0, 1'b0, 1'b0); expect_ack("R5 other cycle-end bits", 4'b0100);
    step(3'b101, 4'b0100, 1'b0, 1'b0, 1'b0); expect_ack("R7 preempt dma", 4'b0001);
    step(3'b111, 4'b0000, 1'b0, 1'b0, 1'b0); expect_ack("R5 offchip keeps", 4'b0001);
    step(3'b110, 4'b0000, 1'b0, 1'b0, 1'b0); expect_ack("R6 R4 drop to refresh", 4'b0010);
    step(3'b000, 4'b0000, 1'b0, 1'b0, 1'b0); expect_ack("R6 drop to cpu", 4'b1000);
    step(3'b100, 4'b0000, 1'b0, 1'b1, 1'b0); expect_ack("R10 internal", 4'b0100);
    step(3'b000, 4'b0000, 1'b0, 1'b0, 1'b0); expect_ack("R6 back to cpu", 4'b1000);
    step(3'b010, 4'b0000, 1'b0, 1'b0, 1'b1); expect_ack("R11 sleep", 4'b0010);
    step(3'b000, 4'b0000, 1'b0, 1'b0, 1'b0); expect_ack("R6 back to cpu", 4'b1000);
    step(3'b111, 4'b0000, 1'b0, 1'b0, 1'b1); expect_ack("R4 simultaneous", 4'b0001);
    step(3'b000, 4'b0000, 1'b0, 1'b0, 1'b0); expect_ack("R6 release", 4'b1000);
    step(3'b110, 4'b1000, 1'b0, 1'b0, 1'b0); expect_ack("R4 refresh over dma", 4'b0010);

    for (int n = 0; n < 4000; n++) begin
      logic [2:0] r;
      r = bus_req;
      for (int k = 0; k < 3; k++)
        if (($urandom % 5) == 0) r[k] = ~r[k];
      step(r, 4'($urandom), ($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 8) == 0);
    end
    finish_run();
  end
endmodule